// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital control for a 10-bit successive-approximation converter. It divides the system clock down to a conversion tick. It holds the sample switch closed for a programmable acquisition window. It then opens the switch and resolves the result one bit at a time, from the most significant bit down. Each trial code goes out to an external DAC, and an external comparator returns a one-bit decision for each trial. The analog parts stay outside; this block sees only a comparator bit and drives only a switch control and a code.

Software drives the block through a small write bus with three selects: control, result and flag clear. The start bit reads back as a busy/done indication. A conversion can also be launched by an external trigger pulse when the trigger-mode field holds the special code. That same pulse clears an associated timer. Clearing the start bit while a conversion runs abandons it, and the last good result is kept. After every conversion or abort there is a short hold-off before the sequencer samples again.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, go_o, irq_o and timer_clr_o are 0, result_o and dac_code_o are 0, and sample_sw_o is 1 (switch closed).
- R2: A control write (select 0) uses this layout: bit0 enable, bit1 start, bits 4:2 acquisition code, bits 8:5 divider, bits 12:9 trigger mode. While enabled, conv_tick_o pulses once every divider+1 clocks. While disabled it never pulses.
- R3: The acquisition code maps to a number of ticks: 000→0, 001→2, 010→4, 011→6, 100→8, 101→12, 110→16, 111→20. Once go_o rises, sample_sw_o falls on tick number (ticks+1).
- R4: A conversion lasts 11 ticks, counted from the fall of sample_sw_o to the fall of go_o. The first tick is the disconnect period. The next ten resolve bits 9 down to 0. A comparator input of 1 keeps the trial bit and 0 clears it, so the result equals the analog code.
- R5: On the clock edge that completes a conversion, result_o is loaded, go_o clears, irq_o sets and sample_sw_o returns to 1.
- R6: A control write with start or enable at 0 during a conversion aborts it. go_o clears, sample_sw_o returns to 1, result_o is unchanged and irq_o does not set.
- R7: After a completion, a start request made at once opens the switch (acquisition code 000) on the third tick after completion, because there is a two-tick hold-off.
- R8: A start is honoured only if enable was already set before the write. A write that sets enable and start together leaves go_o at 0.
- R9: With trigger mode 1011 and enable set, a trig_i pulse sets go_o and runs a conversion. timer_clr_o pulses one clock after the trigger.
- R10: With trigger mode 1011 and enable clear, a trigger pulses timer_clr_o but leaves go_o at 0. With any other trigger mode, a trigger does neither.
- R11: irq_o stays set until a write to select 2 with bit0 = 1.
- R12: A write to select 1 loads bits 9:0 into result_o only when the sequencer is idle with go_o at 0. Otherwise the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 control, 1 result, 2 flag clear |
| wr_data_i | input | 13 | Write data |
| trig_i | input | 1 | External special-event trigger pulse |
| comp_i | input | 1 | Comparator decision, 1 = input at or above trial code |
| go_o | output | 1 | Start/busy bit |
| irq_o | output | 1 | Sticky conversion-complete flag |
| result_o | output | 10 | Last completed or written result |
| sample_sw_o | output | 1 | Sample switch control, 1 = connected |
| dac_code_o | output | 10 | Trial code for the external DAC |
| conv_tick_o | output | 1 | Conversion-clock tick |
| timer_clr_o | output | 1 | Timer clear pulse for the associated timer |

## Verification
A phase counter off by one shows directly as a wrong tick count: either before sample_sw_o falls or between that fall and the fall of go_o. Both are visible within one acquisition or conversion. A wrong keep/clear decision in the bit engine gives a wrong result_o at completion, which is at most 11 ticks after the switch opens. Using an analog code with alternating bits, plus the all-zeros and all-ones codes, catches a stuck or swapped bit. A broken abort path or idle gate shows as a changed result_o or a set irq_o right after the abort write.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ACQ,
    PH_CONV,
    PH_HOLD
  } phase_e;

  localparam int ACQ_CODE_W = 3;
  localparam int ACQ_CNT_W  = 5;
  localparam int TRIG_W     = 4;
  localparam logic [TRIG_W-1:0] TRIG_SPECIAL = 4'b1011;

  localparam logic [1:0] SEL_CTRL   = 2'd0;
  localparam logic [1:0] SEL_RESULT = 2'd1;
  localparam logic [1:0] SEL_FLAG   = 2'd2;

  function automatic logic [ACQ_CNT_W-1:0] acq_ticks(input logic [ACQ_CODE_W-1:0] code);
    logic [ACQ_CNT_W-1:0] n;
    case (code)
      3'd0:    n = 5'd0;
      3'd1:    n = 5'd2;
      3'd2:    n = 5'd4;
      3'd3:    n = 5'd6;
      3'd4:    n = 5'd8;
      3'd5:    n = 5'd12;
      3'd6:    n = 5'd16;
      default: n = 5'd20;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sar_tick_div.sv
module sar_tick_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (cnt >= div_i) begin
      cnt    <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      tick_o <= 1'b0;
    end
  end

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             begin_i,
  input  logic             step_i,
  input  logic             comp_i,
  output logic [RES_W-1:0] code_o,
  output logic [RES_W-1:0] resolved_o
);

  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);

  logic [IDX_W-1:0] idx;

  // Current code with the bit under trial replaced by the comparator decision.
  always_comb begin
    resolved_o      = code_o;
    resolved_o[idx] = comp_i;
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      code_o <= '0;
      idx    <= TOP_IDX;
    end else if (begin_i) begin
      code_o          <= '0;
      code_o[TOP_IDX] <= 1'b1;
      idx             <= TOP_IDX;
    end else if (step_i) begin
      code_o[idx] <= comp_i;
      if (idx != '0) begin
        code_o[idx - 1'b1] <= 1'b1;
        idx                <= idx - 1'b1;
      end
    end
  end

endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int CNT_IN_W   = 5,
  parameter int HOLD_TICKS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_i,
  input  logic                go_i,
  input  logic                abort_i,
  input  logic [CNT_IN_W-1:0] acq_ticks_i,
  output logic                sample_sw_o,
  output logic                done_o,
  output logic                sar_clear_o,
  output logic                sar_begin_o,
  output logic                sar_step_o,
  output phase_e              phase_o
);

  localparam int STEP_W = $clog2(RES_W + 1);
  localparam int CW     = (CNT_IN_W > STEP_W) ? CNT_IN_W : STEP_W;
  localparam logic [CW-1:0] LAST_STEP = CW'(RES_W);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_TICKS - 1);
  localparam logic [CW-1:0] ONE       = CW'(1);

  phase_e        ph;
  logic [CW-1:0] cnt;
  logic          in_conv;
  logic          active;

  assign phase_o     = ph;
  assign in_conv     = (ph == PH_CONV);
  assign active      = (ph == PH_ACQ) || (ph == PH_CONV);
  assign sar_begin_o = tick_i & in_conv & (cnt == '0) & ~abort_i;
  assign sar_step_o  = tick_i & in_conv & (cnt != '0) & ~abort_i;
  assign done_o      = sar_step_o & (cnt == LAST_STEP);
  assign sar_clear_o = (abort_i & active) | done_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph          <= PH_IDLE;
      cnt         <= '0;
      sample_sw_o <= 1'b1;
    end else if (abort_i && active) begin
      ph          <= PH_HOLD;
      cnt         <= HOLD_LAST;
      sample_sw_o <= 1'b1;
    end else if (tick_i) begin
      case (ph)
        PH_IDLE: begin
          if (go_i && !abort_i) begin
            if (acq_ticks_i == '0) begin
              ph          <= PH_CONV;
              cnt         <= '0;
              sample_sw_o <= 1'b0;
            end else begin
              ph  <= PH_ACQ;
              cnt <= CW'(acq_ticks_i) - ONE;
            end
          end
        end
        PH_ACQ: begin
          if (cnt == '0) begin
            ph          <= PH_CONV;
            sample_sw_o <= 1'b0;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        PH_CONV: begin
          if (cnt == LAST_STEP) begin
            ph          <= PH_HOLD;
            cnt         <= HOLD_LAST;
            sample_sw_o <= 1'b1;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        PH_HOLD: begin
          if (cnt == '0) ph <= PH_IDLE;
          else           cnt <= cnt - ONE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int DIV_W = 4
) (
  input  logic                                              clk,
  input  logic                                              rst,
  input  logic                                              wr_en_i,
  input  logic [1:0]                                        wr_sel_i,
  input  logic [((2+ACQ_CODE_W+DIV_W+TRIG_W) > RES_W ?
                 (2+ACQ_CODE_W+DIV_W+TRIG_W) : RES_W)-1:0]  wr_data_i,
  input  logic                                              trig_i,
  input  logic                                              comp_i,
  output logic                                              go_o,
  output logic                                              irq_o,
  output logic [RES_W-1:0]                                  result_o,
  output logic                                              sample_sw_o,
  output logic [RES_W-1:0]                                  dac_code_o,
  output logic                                              conv_tick_o,
  output logic                                              timer_clr_o
);

  localparam int EN_BIT  = 0;
  localparam int GO_BIT  = 1;
  localparam int ACQ_LO  = 2;
  localparam int DIV_LO  = ACQ_LO + ACQ_CODE_W;
  localparam int TRIG_LO = DIV_LO + DIV_W;

  logic                  en_q;
  logic [ACQ_CODE_W-1:0] acq_q;
  logic [DIV_W-1:0]      div_q;
  logic [TRIG_W-1:0]     trig_mode_q;
  logic                  wr_ctrl, wr_result, wr_flag;
  logic                  sw_start, sw_abort, trig_hit, trig_start;
  logic                  fsm_done, sar_clear, sar_begin, sar_step;
  logic                  res_wr_ok;
  logic [RES_W-1:0]      resolved;
  phase_e                phase;

  assign wr_ctrl   = wr_en_i && (wr_sel_i == SEL_CTRL);
  assign wr_result = wr_en_i && (wr_sel_i == SEL_RESULT);
  assign wr_flag   = wr_en_i && (wr_sel_i == SEL_FLAG);

  // Start is honoured only when the enable was already on before this write.
  assign sw_start   = wr_ctrl && wr_data_i[EN_BIT] && wr_data_i[GO_BIT] && en_q && !go_o;
  assign sw_abort   = wr_ctrl && go_o && !(wr_data_i[EN_BIT] && wr_data_i[GO_BIT]);
  assign trig_hit   = trig_i && (trig_mode_q == TRIG_SPECIAL);
  assign trig_start = trig_hit && en_q && !go_o && !sw_abort;
  assign res_wr_ok  = wr_result && (phase == PH_IDLE) && !go_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q        <= 1'b0;
      acq_q       <= '0;
      div_q       <= '0;
      trig_mode_q <= '0;
    end else if (wr_ctrl) begin
      en_q        <= wr_data_i[EN_BIT];
      acq_q       <= wr_data_i[ACQ_LO +: ACQ_CODE_W];
      div_q       <= wr_data_i[DIV_LO +: DIV_W];
      trig_mode_q <= wr_data_i[TRIG_LO +: TRIG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      go_o        <= 1'b0;
      irq_o       <= 1'b0;
      result_o    <= '0;
      timer_clr_o <= 1'b0;
    end else begin
      timer_clr_o <= trig_hit;

      if (fsm_done || sw_abort)      go_o <= 1'b0;
      else if (sw_start || trig_start) go_o <= 1'b1;

      if (fsm_done)                   irq_o <= 1'b1;
      else if (wr_flag && wr_data_i[0]) irq_o <= 1'b0;

      if (fsm_done)       result_o <= resolved;
      else if (res_wr_ok) result_o <= wr_data_i[RES_W-1:0];
    end
  end

  sar_tick_div #(.DIV_W(DIV_W)) div_i (
    .clk    (clk),
    .rst    (rst),
    .en_i   (en_q),
    .div_i  (div_q),
    .tick_o (conv_tick_o)
  );

  sar_seq_fsm #(
    .RES_W      (RES_W),
    .CNT_IN_W   (ACQ_CNT_W),
    .HOLD_TICKS (2)
  ) fsm_i (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (conv_tick_o),
    .go_i        (go_o),
    .abort_i     (sw_abort),
    .acq_ticks_i (acq_ticks(acq_q)),
    .sample_sw_o (sample_sw_o),
    .done_o      (fsm_done),
    .sar_clear_o (sar_clear),
    .sar_begin_o (sar_begin),
    .sar_step_o  (sar_step),
    .phase_o     (phase)
  );

  sar_bit_engine #(.RES_W(RES_W)) eng_i (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (sar_clear),
    .begin_i    (sar_begin),
    .step_i     (sar_step),
    .comp_i     (comp_i),
    .code_o     (dac_code_o),
    .resolved_o (resolved)
  );

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             go_o,
  input logic             irq_o,
  input logic             sample_sw_o,
  input logic [RES_W-1:0] result_o,
  input logic             timer_clr_o,
  input logic             trig_i,
  input logic             en_q,
  input logic             fsm_done,
  input logic             res_wr_ok
);

  // R4 / R6: the switch is only open while a conversion is owned by go
  p_switch_open_needs_go_r6: assert property (@(posedge clk) disable iff (rst)
    !sample_sw_o |-> go_o);

  p_start_needs_prior_enable_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(go_o) |-> $past(en_q));

  p_result_source_r12: assert property (@(posedge clk) disable iff (rst)
    !$stable(result_o) |-> $past(fsm_done || res_wr_ok));

  p_irq_only_on_done_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(fsm_done));

  p_done_clears_go_r5: assert property (@(posedge clk) disable iff (rst)
    fsm_done |=> !go_o);

  p_timer_clear_from_trigger_r9: assert property (@(posedge clk) disable iff (rst)
    timer_clr_o |-> $past(trig_i));

endmodule

bind sar_seq_top sar_seq_chk #(.RES_W(RES_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .go_o        (go_o),
  .irq_o       (irq_o),
  .sample_sw_o (sample_sw_o),
  .result_o    (result_o),
  .timer_clr_o (timer_clr_o),
  .trig_i      (trig_i),
  .en_q        (en_q),
  .fsm_done    (fsm_done),
  .res_wr_ok   (res_wr_ok)
);

// File: tb/sar_seq_top_tb_top.sv
module sar_seq_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [12:0] wr_data = '0;
  logic        trig = 1'b0;
  logic        comp;
  logic        go, irq, sw, tick, tclr;
  logic [9:0]  result, dac;
  logic [9:0]  analog_v = '0;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  assign comp = (analog_v >= dac);

  sar_seq_top dut_i (
    .clk (clk), .rst (rst), .wr_en_i (wr_en), .wr_sel_i (wr_sel),
    .wr_data_i (wr_data), .trig_i (trig), .comp_i (comp),
    .go_o (go), .irq_o (irq), .result_o (result), .sample_sw_o (sw),
    .dac_code_o (dac), .conv_tick_o (tick), .timer_clr_o (tclr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [12:0] ctl(input bit en, input bit st, input logic [2:0] acq,
                                      input logic [3:0] dv, input logic [3:0] tm);
    return {tm, dv, acq, st, en};
  endfunction

  task automatic bus_write(input logic [1:0] sel, input logic [12:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_acq(output int n);
    n = 0;
    for (int i = 0; i < 3000 && sw; i++) begin
      if (tick) n++;
      @(negedge clk);
    end
  endtask

  task automatic count_conv(output int n);
    n = 0;
    for (int i = 0; i < 3000 && go; i++) begin
      if (tick) n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 go", go, 0);
    chk("R1 irq", irq, 0);
    chk("R1 result", result, 0);
    chk("R1 sample switch", sw, 1);
    chk("R1 dac", dac, 0);
    chk("R1 timer clear", tclr, 0);
  endtask

  task automatic t_tick();
    int n = 0;
    idle(30);
    for (int i = 0; i < 30; i++) begin if (tick) n++; @(negedge clk); end
    chk("R2 no tick while disabled", n, 0);
    bus_write(2'd0, ctl(1, 0, 3'd0, 4'd2, 4'd0));
    idle(6);
    n = 0;
    for (int i = 0; i < 30; i++) begin if (tick) n++; @(negedge clk); end
    chk("R2 ticks in 30 clocks div=2", n, 10);
  endtask

  task automatic t_convert(input logic [2:0] acq, input logic [9:0] v, input int exp_acq);
    int na, nc;
    analog_v = v;
    bus_write(2'd0, ctl(1, 1, acq, 4'd2, 4'd0));
    chk("R3 go raised", go, 1);
    count_acq(na);
    chk($sformatf("R3 acquisition ticks code %0d", acq), na, exp_acq);
    count_conv(nc);
    chk("R4 conversion ticks", nc, 11);
    chk($sformatf("R4 result for %0d", v), result, v);
    chk("R5 irq set", irq, 1);
    chk("R5 switch closed", sw, 1);
    idle(20);
  endtask

  task automatic t_irq_sticky();
    idle(25);
    chk("R11 irq held", irq, 1);
    bus_write(2'd2, 13'd0);
    chk("R11 clear with bit0=0 ignored", irq, 1);
    bus_write(2'd2, 13'd1);
    chk("R11 irq cleared", irq, 0);
  endtask

  task automatic t_abort();
    t_convert(3'd0, 10'h155, 1);
    bus_write(2'd2, 13'd1);
    analog_v = 10'h2AA;
    bus_write(2'd0, ctl(1, 1, 3'd0, 4'd2, 4'd0));
    for (int i = 0; i < 300 && sw; i++) @(negedge clk);
    idle(8);
    bus_write(2'd1, 13'h0F0);
    chk("R12 busy result write ignored", result, 10'h155);
    bus_write(2'd0, ctl(1, 0, 3'd0, 4'd2, 4'd0));
    chk("R6 go cleared by abort", go, 0);
    chk("R6 switch closed by abort", sw, 1);
    chk("R6 result kept", result, 10'h155);
    idle(40);
    chk("R6 no irq after abort", irq, 0);
    chk("R6 result still kept", result, 10'h155);
    bus_write(2'd1, 13'h3C3);
    chk("R12 idle result write", result, 10'h3C3);
  endtask

  task automatic t_holdoff();
    int n = 0;
    analog_v = 10'h0F0;
    bus_write(2'd0, ctl(1, 1, 3'd0, 4'd2, 4'd0));
    for (int i = 0; i < 300 && go; i++) @(negedge clk);
    chk("R5 result before restart", result, 10'h0F0);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = ctl(1, 1, 3'd0, 4'd2, 4'd0);
    if (tick) n++;
    @(negedge clk);
    wr_en = 1'b0;
    for (int i = 0; i < 300 && sw; i++) begin
      if (tick) n++;
      @(negedge clk);
    end
    chk("R7 ticks from completion to next switch open", n, 3);
    for (int i = 0; i < 300 && go; i++) @(negedge clk);
    idle(20);
    bus_write(2'd2, 13'd1);
  endtask

  task automatic t_same_write();
    bus_write(2'd0, ctl(0, 0, 3'd0, 4'd2, 4'd0));
    bus_write(2'd0, ctl(1, 1, 3'd0, 4'd2, 4'd0));
    chk("R8 go stays low on enabling write", go, 0);
    idle(30);
    chk("R8 switch stays closed", sw, 1);
    chk("R8 go still low", go, 0);
  endtask

  task automatic pulse_trig();
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic t_trigger();
    int nc;
    analog_v = 10'h1E7;
    bus_write(2'd0, ctl(1, 0, 3'd1, 4'd2, 4'b1011));
    pulse_trig();
    chk("R9 timer clear pulse", tclr, 1);
    chk("R9 go set by trigger", go, 1);
    @(negedge clk);
    chk("R9 timer clear one cycle", tclr, 0);
    for (int i = 0; i < 300 && sw; i++) @(negedge clk);
    count_conv(nc);
    chk("R9 triggered result", result, 10'h1E7);
    idle(20);
    bus_write(2'd0, ctl(0, 0, 3'd1, 4'd2, 4'b1011));
    pulse_trig();
    chk("R10 timer clear while disabled", tclr, 1);
    chk("R10 no start while disabled", go, 0);
    bus_write(2'd0, ctl(1, 0, 3'd1, 4'd2, 4'b0011));
    pulse_trig();
    chk("R10 other mode no timer clear", tclr, 0);
    chk("R10 other mode no start", go, 0);
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_tick();
    t_convert(3'd0, 10'h2A5, 1);
    t_convert(3'd2, 10'h000, 5);
    t_convert(3'd5, 10'h3FF, 13);
    t_irq_sticky();
    t_abort();
    t_holdoff();
    t_same_write();
    t_trigger();
    done_flag = 1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog (R1-R12 run) actual=timeout expected=finished");
      report();
    end
  end

endmodule